// File: doc/BRIEF.md
# Multi-CPU Interrupt Distributor

This block collects level-sensitive interrupt sources and presents them to up to four CPUs. Every source passes through a global enable bit and a per-CPU mask bit. A shared source additionally needs the CPU's bit set in that source's routing register. Three source numbers are private to each CPU and take their level from per-CPU inputs instead of the shared input vector. Source 0 is the inter-processor doorbell summary, source 1 is the message doorbell summary and source 5 is the local timer.

Software changes enables and masks by writing a source number to a set address or a clear address, so no read-modify-write of a bitmap is needed. Each CPU has its own view of the register bus, selected by `bus_local` and `bus_cpu`. Through that view a CPU reads an acknowledge register, which names its lowest-numbered qualifying source, and a cause bitmap of its private sources. Each CPU has one registered interrupt line.

Top module: `irq_distributor`

## Requirements
- R1: After reset all global enables are clear, every source is masked for every CPU, all routing registers are zero, `irq_out` is all zeros and every acknowledge read returns 1023.
- R2: A global-window write to address 0x30 sets the global enable of the source whose number is in `bus_wdata[9:0]`, and a write to 0x34 clears it. A number not below NSRC changes no state.
- R3: A local-window write to 0x48 masks the source number in `bus_wdata[9:0]` for the CPU given by `bus_cpu` only, and a write to 0x4C unmasks it for that CPU only.
- R4: The routing register of source i sits at global address 0x100 + 4·i. Bit c of its low NCPU bits sends shared source i to CPU c. A global read returns the stored bits.
- R5: Sources 0, 1 and 5 take their level from `ipi_bell[c]`, `msg_bell[c]` and `tmr_irq[c]` for each CPU c. They ignore the routing registers and ignore `irq_src` bits 0, 1 and 5.
- R6: A source qualifies for CPU c when its level is high, it is globally enabled, it is unmasked for c, and it is either private or routed to c. It stops qualifying as soon as its level drops.
- R7: A local read of 0x44 returns, in bits [9:0], the lowest qualifying source number for that CPU, or 1023 when none qualifies. The read changes no state.
- R8: `irq_out[c]` is the OR of CPU c's qualifying sources, registered once. It reflects the state seen at the previous clock edge.
- R9: A global read of 0x00 returns NSRC in bits [11:2] and zero elsewhere.
- R10: A local read of 0x10 returns the CPU's qualifying private sources as a bitmap: bit 0 for source 1, bit 1 for source 0 and bit 2 for source 5.
- R11: Read data appears on `bus_rdata` one cycle after `bus_rd`. It shows the state from before a write made in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_local | input | 1 | 1 selects the per-CPU window, 0 the global window |
| bus_cpu | input | CPUW | CPU whose per-CPU window is accessed |
| bus_addr | input | 12 | Byte address within the selected window |
| bus_wdata | input | 10 | Write data: a source number or routing bits |
| bus_rdata | output | 32 | Registered read data |
| irq_src | input | NSRC | Shared source levels |
| ipi_bell | input | NCPU | Per-CPU doorbell summary level (source 0) |
| msg_bell | input | NCPU | Per-CPU message doorbell level (source 1) |
| tmr_irq | input | NCPU | Per-CPU timer level (source 5) |
| irq_out | output | NCPU | Registered interrupt line per CPU |

## Verification
Two cases can fall in the same cycle.

The first is an enable-clear write that lands on the same edge as its source rising. The bench drives both at one falling edge. It expects `irq_out` to rise for exactly one cycle, because the register sampled the old enable, and to fall on the next edge.

The second is a write and a read of the same routing register in one cycle. The bench expects the read to return the old value and a later read to return the new one.

Random sequences of writes and level changes are judged against a bench model of the enable, mask and routing state.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
    localparam int IDXW = 10;
    localparam logic [IDXW-1:0] NO_SRC = 10'd1023;

    localparam logic [11:0] A_CTRL    = 12'h000;
    localparam logic [11:0] A_EN_SET  = 12'h030;
    localparam logic [11:0] A_EN_CLR  = 12'h034;
    localparam logic [11:0] A_CAUSE   = 12'h010;
    localparam logic [11:0] A_ACK     = 12'h044;
    localparam logic [11:0] A_MSK_SET = 12'h048;
    localparam logic [11:0] A_MSK_CLR = 12'h04C;
    localparam logic [IDXW-1:0] ROUTE_WORD0 = 10'h040;

    localparam int SRC_IPI = 0;
    localparam int SRC_MSG = 1;
    localparam int SRC_TMR = 5;

    function automatic logic is_private(int i);
        return (i == SRC_IPI) || (i == SRC_MSG) || (i == SRC_TMR);
    endfunction
endpackage

// File: rtl/irqd_cfg.sv
module irqd_cfg
    import irqd_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int NCPU = 4,
    parameter int CPUW = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr,
    input  logic                           local_win,
    input  logic [CPUW-1:0]                cpu,
    input  logic [11:0]                    addr,
    input  logic [IDXW-1:0]                wdata,
    output logic [NSRC-1:0]                enable,
    output logic [NCPU-1:0][NSRC-1:0]      mask,
    output logic [NSRC-1:0][NCPU-1:0]      route
);
    localparam logic [IDXW:0] SRC_LIM = (IDXW+1)'(NSRC);

    logic            idx_ok, en_set, en_clr, msk_set, msk_clr, rt_hit;
    logic [IDXW-1:0] rt_idx;
    logic [NSRC-1:0] idx_dec;
    logic [NCPU-1:0] cpu_sel;

    assign idx_ok  = {1'b0, wdata} < SRC_LIM;
    assign en_set  = wr && !local_win && addr == A_EN_SET && idx_ok;
    assign en_clr  = wr && !local_win && addr == A_EN_CLR && idx_ok;
    assign msk_set = wr && local_win && addr == A_MSK_SET && idx_ok;
    assign msk_clr = wr && local_win && addr == A_MSK_CLR && idx_ok;
    assign rt_idx  = addr[11:2] - ROUTE_WORD0;
    assign rt_hit  = wr && !local_win && addr[11:8] != 4'd0 && addr[1:0] == 2'd0
                     && ({1'b0, rt_idx} < SRC_LIM);

    always_comb begin
        for (int i = 0; i < NSRC; i++) idx_dec[i] = (wdata == IDXW'(i));
    end

    for (genvar c = 0; c < NCPU; c++) begin : g_sel
        assign cpu_sel[c] = (cpu == CPUW'(c));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable <= '0;
            mask   <= '1;
            route  <= '0;
        end else begin
            if (en_set) enable <= enable | idx_dec;
            if (en_clr) enable <= enable & ~idx_dec;
            for (int c = 0; c < NCPU; c++) begin
                if (msk_set && cpu_sel[c]) mask[c] <= mask[c] | idx_dec;
                if (msk_clr && cpu_sel[c]) mask[c] <= mask[c] & ~idx_dec;
            end
            for (int i = 0; i < NSRC; i++) begin
                if (rt_hit && rt_idx == IDXW'(i)) route[i] <= wdata[NCPU-1:0];
            end
        end
    end

    // R2
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_set |=> ((enable & $past(idx_dec)) == $past(idx_dec)));
    // R2
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en_clr |=> ((enable & $past(idx_dec)) == '0));
    // R3
    msk_cpu_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msk_set || msk_clr) |-> $onehot0(cpu_sel));
endmodule

// File: rtl/irqd_cpu_port.sv
module irqd_cpu_port
    import irqd_pkg::*;
#(
    parameter int NSRC = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSRC-1:0]      src_lvl,
    input  logic                 ipi,
    input  logic                 msg,
    input  logic                 tmr,
    input  logic [NSRC-1:0]      enable,
    input  logic [NSRC-1:0]      mask_row,
    input  logic [NSRC-1:0]      route_col,
    output logic [IDXW-1:0]      ack,
    output logic [2:0]           cause,
    output logic                 irq_q
);
    logic [NSRC-1:0] lvl, qual;

    always_comb begin
        lvl          = src_lvl;
        lvl[SRC_IPI] = ipi;
        lvl[SRC_MSG] = msg;
        lvl[SRC_TMR] = tmr;
        for (int i = 0; i < NSRC; i++) begin
            qual[i] = lvl[i] && enable[i] && !mask_row[i]
                      && (is_private(i) || route_col[i]);
        end
    end

    always_comb begin
        ack = NO_SRC;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (qual[i]) ack = IDXW'(i);
        end
    end

    assign cause = {qual[SRC_TMR], qual[SRC_IPI], qual[SRC_MSG]};

    always_ff @(posedge clk) begin
        if (!rst_n) irq_q <= 1'b0;
        else        irq_q <= |qual;
    end

    // R7
    ack_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack == NO_SRC) |-> (qual == '0));
    // R7
    ack_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack != NO_SRC) |-> ({1'b0, ack} < (IDXW+1)'(NSRC)));
    // R6
    ack_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack == IDXW'(SRC_TMR)) |-> (tmr && !qual[SRC_IPI] && !qual[SRC_MSG]));
    // R8
    irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (irq_q == $past(ack != NO_SRC)));
endmodule

// File: rtl/irq_distributor.sv
module irq_distributor
    import irqd_pkg::*;
#(
    parameter int NSRC = 32,
    parameter int NCPU = 4,
    parameter int CPUW = (NCPU > 1) ? $clog2(NCPU) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic             bus_local,
    input  logic [CPUW-1:0]  bus_cpu,
    input  logic [11:0]      bus_addr,
    input  logic [IDXW-1:0]  bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic [NSRC-1:0]  irq_src,
    input  logic [NCPU-1:0]  ipi_bell,
    input  logic [NCPU-1:0]  msg_bell,
    input  logic [NCPU-1:0]  tmr_irq,
    output logic [NCPU-1:0]  irq_out
);
    localparam logic [IDXW:0] SRC_LIM = (IDXW+1)'(NSRC);

    logic [NSRC-1:0]           enable;
    logic [NCPU-1:0][NSRC-1:0] mask;
    logic [NSRC-1:0][NCPU-1:0] route;
    logic [IDXW-1:0]           ack_v   [NCPU];
    logic [2:0]                cause_v [NCPU];
    logic [IDXW-1:0]           rd_idx;
    logic                      rd_route;
    logic [31:0]               read_val;

    irqd_cfg #(.NSRC(NSRC), .NCPU(NCPU), .CPUW(CPUW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .local_win(bus_local),
        .cpu(bus_cpu), .addr(bus_addr), .wdata(bus_wdata),
        .enable(enable), .mask(mask), .route(route)
    );

    for (genvar c = 0; c < NCPU; c++) begin : g_cpu
        logic [NSRC-1:0] route_col;
        for (genvar i = 0; i < NSRC; i++) begin : g_col
            assign route_col[i] = route[i][c];
        end
        irqd_cpu_port #(.NSRC(NSRC)) u_port (
            .clk(clk), .rst_n(rst_n), .src_lvl(irq_src),
            .ipi(ipi_bell[c]), .msg(msg_bell[c]), .tmr(tmr_irq[c]),
            .enable(enable), .mask_row(mask[c]), .route_col(route_col),
            .ack(ack_v[c]), .cause(cause_v[c]), .irq_q(irq_out[c])
        );
    end

    assign rd_idx   = bus_addr[11:2] - ROUTE_WORD0;
    assign rd_route = bus_addr[11:8] != 4'd0 && bus_addr[1:0] == 2'd0
                      && ({1'b0, rd_idx} < SRC_LIM);

    always_comb begin
        read_val = '0;
        if (!bus_local) begin
            if (bus_addr == A_CTRL) begin
                read_val[11:2] = IDXW'(NSRC);
            end else if (rd_route) begin
                for (int i = 0; i < NSRC; i++) begin
                    if (rd_idx == IDXW'(i)) read_val[NCPU-1:0] = route[i];
                end
            end
        end else begin
            for (int c = 0; c < NCPU; c++) begin
                if (bus_cpu == CPUW'(c)) begin
                    if (bus_addr == A_ACK)   read_val[IDXW-1:0] = ack_v[c];
                    if (bus_addr == A_CAUSE) read_val[2:0]      = cause_v[c];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= read_val;
    end

    // R1
    irq_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (irq_out == '0));
    // R11
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));
endmodule

// File: tb/tb_irq_distributor.sv
module tb_irq_distributor;
    localparam int NS = 32;
    localparam int NC = 4;
    localparam int NONE = 1023;

    logic        clk = 0, rst_n = 0;
    logic        bus_wr = 0, bus_rd = 0, bus_local = 0;
    logic [1:0]  bus_cpu = 0;
    logic [11:0] bus_addr = 0;
    logic [9:0]  bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic [NS-1:0] src = 0;
    logic [NC-1:0] ipi = 0, msg = 0, tmr = 0, irq_out;

    int n_chk = 0, n_bad = 0;
    bit m_en [NS];
    bit m_mask [NC][NS];
    bit m_route [NS][NC];

    always #10 clk = ~clk;

    irq_distributor #(.NSRC(NS), .NCPU(NC)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_local(bus_local), .bus_cpu(bus_cpu), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_src(src),
        .ipi_bell(ipi), .msg_bell(msg), .tmr_irq(tmr), .irq_out(irq_out)
    );

    function automatic bit is_priv(int i);
        return i == 0 || i == 1 || i == 5;
    endfunction

    function automatic bit m_lvl(int c, int i);
        if (i == 0) return ipi[c];
        if (i == 1) return msg[c];
        if (i == 5) return tmr[c];
        return src[i];
    endfunction

    function automatic bit m_qual(int c, int i);
        return m_lvl(c, i) && m_en[i] && !m_mask[c][i] && (is_priv(i) || m_route[i][c]);
    endfunction

    function automatic int m_ack(int c);
        for (int i = 0; i < NS; i++) if (m_qual(c, i)) return i;
        return NONE;
    endfunction

    function automatic int m_irq();
        int v = 0;
        for (int c = 0; c < NC; c++) if (m_ack(c) != NONE) v |= (1 << c);
        return v;
    endfunction

    function automatic int m_cause(int c);
        return {29'd0, m_qual(c, 5), m_qual(c, 0), m_qual(c, 1)};
    endfunction

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(bit loc, int cpu, int a, int d);
        bus_local = loc; bus_cpu = cpu[1:0]; bus_addr = a[11:0]; bus_wdata = d[9:0];
        bus_wr = 1;
        @(posedge clk); @(negedge clk);
        bus_wr = 0;
        if (!loc) begin
            if (a == 'h30 && d < NS) m_en[d] = 1;
            if (a == 'h34 && d < NS) m_en[d] = 0;
            if (a >= 'h100 && a % 4 == 0 && (a - 'h100) / 4 < NS)
                for (int c = 0; c < NC; c++) m_route[(a - 'h100) / 4][c] = d[c];
        end else if (d < NS) begin
            if (a == 'h48) m_mask[cpu][d] = 1;
            if (a == 'h4C) m_mask[cpu][d] = 0;
        end
    endtask

    task automatic rd(bit loc, int cpu, int a, output int v);
        bus_local = loc; bus_cpu = cpu[1:0]; bus_addr = a[11:0];
        bus_rd = 1;
        @(posedge clk); @(negedge clk);
        bus_rd = 0;
        v = bus_rdata;
    endtask

    task automatic chk_irq(string req);
        @(posedge clk); @(negedge clk);
        chk(req, int'(irq_out), m_irq());
    endtask

    task automatic chk_ack(string req, int c);
        int v;
        rd(1, c, 'h44, v);
        chk(req, v, m_ack(c));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin : main
        int v, v2;
        for (int i = 0; i < NS; i++) begin
            m_en[i] = 0;
            for (int c = 0; c < NC; c++) begin m_mask[c][i] = 1; m_route[i][c] = 0; end
        end
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk("R1 irq_out after reset", int'(irq_out), 0);
        chk_ack("R1 ack after reset", 0);
        rd(0, 0, 'h100 + 4 * 9, v);
        chk("R1 route after reset", v, 0);
        rd(0, 0, 'h000, v);
        chk("R9 control count", v, NS << 2);

        // R8 / R2: enable clear lands with rising source
        wr(0, 0, 'h30, 9);
        wr(0, 0, 'h100 + 4 * 9, 1);
        wr(1, 0, 'h4C, 9);
        chk_irq("R8 idle before race");
        bus_local = 0; bus_addr = 12'h034; bus_wdata = 10'd9; bus_wr = 1; src[9] = 1;
        @(posedge clk); @(negedge clk);
        bus_wr = 0; m_en[9] = 0;
        chk("R8 one-cycle pulse on race", int'(irq_out), 1);
        chk_irq("R2 enable clear wins next cycle");

        // R5: timer private, shared bit 5 ignored
        wr(0, 0, 'h30, 5);
        wr(1, 2, 'h4C, 5);
        src[5] = 1;
        chk_irq("R5 shared bit 5 ignored");
        chk_ack("R5 ack with shared bit 5 only", 2);
        tmr[2] = 1;
        chk_irq("R5 timer raises only cpu2");
        chk_ack("R5 ack timer", 2);
        rd(1, 2, 'h10, v);
        chk("R10 cause timer bit", v, m_cause(2));
        tmr[2] = 0; src[5] = 0;
        chk_irq("R6 level drop clears");

        // R4/R3: routing and per-CPU masking
        wr(0, 0, 'h30, 9);
        wr(0, 0, 'h100 + 4 * 9, 2);
        wr(1, 1, 'h4C, 9);
        chk_irq("R4 routed to cpu1 only");
        rd(0, 0, 'h100 + 4 * 9, v);
        chk("R4 route readback", v, 2);
        wr(0, 0, 'h100 + 4 * 9, 3);
        wr(1, 1, 'h48, 9);
        chk_irq("R3 mask on cpu1 leaves cpu0");

        // R2: out-of-range number
        src[8] = 1;
        wr(0, 0, 'h100 + 4 * 8, 1);
        wr(1, 0, 'h4C, 8);
        wr(0, 0, 'h30, 40);
        chk_ack("R2 out-of-range index ignored", 0);

        // R7 priority and read without side effect
        wr(0, 0, 'h30, 8);
        src[12] = 1;
        wr(0, 0, 'h30, 12);
        wr(0, 0, 'h100 + 4 * 12, 1);
        wr(1, 0, 'h4C, 12);
        chk_ack("R7 lowest pending", 0);
        chk_ack("R7 second read unchanged", 0);

        // R10 message doorbell
        msg[0] = 1;
        wr(0, 0, 'h30, 1);
        wr(1, 0, 'h4C, 1);
        rd(1, 0, 'h10, v);
        chk("R10 cause msg bit", v, 1);
        chk_ack("R5 msg doorbell ack", 0);

        // R11: write and read of one routing register in the same cycle
        bus_local = 0; bus_addr = 12'h100 + 12'd4 * 12'd20; bus_wdata = 10'd6;
        bus_wr = 1; bus_rd = 1;
        @(posedge clk); @(negedge clk);
        bus_wr = 0; bus_rd = 0;
        chk("R11 read sees old value", int'(bus_rdata), 0);
        m_route[20][1] = 1; m_route[20][2] = 1;
        rd(0, 0, 'h100 + 4 * 20, v2);
        chk("R11 later read sees new", v2, 6);

        // random phase
        for (int it = 0; it < 400; it++) begin
            int op = $urandom_range(0, 7);
            int c = $urandom_range(0, NC - 1);
            int idx = $urandom_range(0, NS + 7);
            case (op)
                0:       wr(0, c, 'h30, idx);
                1:       wr(0, c, 'h34, idx);
                2:       wr(1, c, 'h48, idx);
                3, 4:    wr(1, c, 'h4C, idx);
                5:       wr(0, c, 'h100 + 4 * (idx % NS), $urandom_range(0, 15));
                6:       src = $urandom();
                default: begin
                    ipi = 4'($urandom()); msg = 4'($urandom()); tmr = 4'($urandom());
                end
            endcase
            chk_irq("R6 random irq_out");
            chk_ack("R7 random ack", c);
            if (it % 8 == 0) begin
                rd(1, c, 'h10, v);
                chk("R10 random cause", v, m_cause(c));
            end
        end

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule